// File: doc/BRIEF.md
# Power Stage Fault Flag Manager

This block collects the fault sources of a synchronous buck power stage and turns them into one fault flag and two gate commands for the gate controller. The four sources are:

- a high-side overcurrent comparator bit;
- an output overcurrent condition, where a monitor code exceeds a limit code;
- a gate-supply voltage code, checked against undervoltage thresholds;
- a die temperature code, checked against over-temperature thresholds.

The two gate commands are `trunc_hs_o`, which forces the high-side gate off, and `hold_off_o`, which forces both gates off. All analog sensing happens outside the block; only digital bits and codes arrive here.

Every rising edge of the switch node opens a blanking window. The window length is a number of clock cycles, captured while reset is asserted. During the window the high-side comparator is ignored and the monitor code sample is frozen.

The two overcurrent faults behave differently:

- A high-side fault cuts only the PWM pulse in progress. The next pulse tries again.
- An output overcurrent keeps the high side off until the current drops.
- When both occur together, both gates stay off for as long as the output overcurrent lasts.

The overcurrent part of the flag is sticky. It clears only on a PWM falling edge that ends a pulse with no fault seen during its on-time. The supply and thermal conditions clear by themselves. The flag is set from reset until the supply code first reaches the undervoltage release level, so it also serves as a power-not-good indication.

Top module: `ffm_fault_mgr`

## Requirements
- R1: From reset until `vgg_code_i` first reaches UV_RISE (default 88), `fault_flag_o`, `trunc_hs_o` and `hold_off_o` are all 1, including in the first cycle after reset is released.
- R2: A cycle in which `sw_high_i` is 1 and was 0 in the previous cycle starts a blanking window. The window covers that cycle and the following L-1 cycles, where L is the value of `blank_len_i` sampled while `rst_n` is low; L = 0 gives no window. Changes to `blank_len_i` after reset have no effect. During the window `hs_oc_i` is ignored, so a PWM pulse of L cycles or fewer never trips.
- R3: `hs_oc_i` = 1 while `pwm_i` = 1 and outside blanking sets `fault_flag_o`, `trunc_hs_o` and `hold_off_o` one cycle later. This trip holds while `pwm_i` stays 1. It is released one cycle after `pwm_i` falls. Each new PWM pulse starts with no trip and is cut again if the fault persists.
- R4: A held monitor code strictly greater than `lim_code_i`, outside blanking, sets `fault_flag_o` and `trunc_hs_o` but not `hold_off_o`. `trunc_hs_o` stays 1 across later PWM pulses until the held code is at or below the limit outside blanking. A code equal to the limit is not a fault.
- R5: If a high-side trip and an output overcurrent are present together, `hold_off_o` stays 1 across PWM pulses until the output overcurrent ends.
- R6: The overcurrent part of `fault_flag_o` clears one cycle after a PWM falling edge, but only if no high-side or output overcurrent event occurred during that pulse's on-time. After a pulse that saw a fault, it stays set.
- R7: The undervoltage state sets when `vgg_code_i` < UV_FALL (default 86) and releases when `vgg_code_i` >= UV_RISE (default 88). Codes between the two keep the current state. The outputs follow within two cycles.
- R8: The over-temperature state sets when `temp_code_i` >= OT_ENTER (default 165) and releases when `temp_code_i` < OT_EXIT (default 145). Codes between the two keep the current state.
- R9: While undervoltage or over-temperature is active, `fault_flag_o`, `hold_off_o` and `trunc_hs_o` are 1. When the condition ends they return to 0 without any PWM activity.
- R10: The monitor code is sampled only in cycles outside blanking, through one holding register that adds one cycle of latency. A code present only during blanking has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the blanking length is captured while it is low |
| blank_len_i | input | BLANK_W | Blanking length in cycles |
| pwm_i | input | 1 | Resolved PWM command (1 = high-side on-time) |
| sw_high_i | input | 1 | Switch node is high |
| hs_oc_i | input | 1 | High-side overcurrent comparator |
| mon_code_i | input | MON_W | Output current monitor code |
| lim_code_i | input | MON_W | Output current limit code |
| vgg_code_i | input | SUP_W | Gate-supply voltage code |
| temp_code_i | input | SUP_W | Die temperature code |
| fault_flag_o | output | 1 | Registered fault flag |
| trunc_hs_o | output | 1 | Force the high-side gate off |
| hold_off_o | output | 1 | Force both gates off |

## Verification
The in-line assertions check, on every cycle, the relations that hold locally:

- the blanking counter stays within the captured length;
- the monitor sample is frozen while blanking;
- a high-side trip only begins from an unblanked comparator hit during PWM on-time;
- a combined lock only exists under an output overcurrent;
- the overcurrent flag only falls at a PWM falling edge;
- undervoltage always forces both gates off.

Only the bench scenarios can show the behaviours that depend on timing and sequence:

- the exact cycle on which blanking ends;
- that a glitch on the monitor code during blanking is ignored;
- that the high side is retried on every pulse after a high-side fault;
- that a dirty pulse keeps the flag set while a clean one clears it;
- the hysteresis band, swept code by code in both directions.

// File: rtl/ffm_pkg.sv
package ffm_pkg;
   // Direction in which a hysteresis comparator declares its condition
   typedef enum logic {
      SENSE_BELOW = 1'b0,
      SENSE_ABOVE = 1'b1
   } hyst_sense_e;
endpackage

// File: rtl/ffm_hyst.sv
module ffm_hyst
   import ffm_pkg::*;
#(
   parameter int unsigned W           = 8,
   parameter hyst_sense_e SENSE       = SENSE_ABOVE,
   parameter int unsigned ASSERT_LVL  = 165,
   parameter int unsigned RELEASE_LVL = 145,
   parameter bit          RST_ACTIVE  = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] code_i,
   output logic         active_o
);
   localparam logic [W-1:0] ASSERT_C  = W'(ASSERT_LVL);
   localparam logic [W-1:0] RELEASE_C = W'(RELEASE_LVL);

   logic enter_c;
   logic leave_c;

   generate
      if ((ASSERT_LVL >> W) != 0 || (RELEASE_LVL >> W) != 0) begin : g_range_bad
         $error("ffm_hyst: threshold does not fit in W bits");
      end
      if (SENSE == SENSE_ABOVE) begin : g_above
         if (RELEASE_LVL >= ASSERT_LVL) begin : g_order_bad
            $error("ffm_hyst: release level must lie below assert level");
         end
         assign enter_c = (code_i >= ASSERT_C);
         assign leave_c = (code_i < RELEASE_C);
      end else begin : g_below
         if (RELEASE_LVL <= ASSERT_LVL) begin : g_order_bad
            $error("ffm_hyst: release level must lie above assert level");
         end
         assign enter_c = (code_i < ASSERT_C);
         assign leave_c = (code_i >= RELEASE_C);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_o <= RST_ACTIVE;
      end else if (!active_o && enter_c) begin
         active_o <= 1'b1;
      end else if (active_o && leave_c) begin
         active_o <= 1'b0;
      end
   end

   // R7 / R8: a condition only starts from a code on the asserting side
   assert_hyst_enter_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_o) |-> $past(enter_c));
   // R7 / R8: a condition only ends from a code on the releasing side
   assert_hyst_leave_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active_o) |-> $past(leave_c));
endmodule

// File: rtl/ffm_blank.sv
module ffm_blank #(
   parameter int unsigned W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] len_i,
   input  logic         sw_high_i,
   output logic         blank_o
);
   localparam logic [W-1:0] ZERO = '0;

   logic [W-1:0] len_q;
   logic [W-1:0] cnt_q;
   logic         sw_q;
   logic         rise_c;

   assign rise_c  = sw_high_i && !sw_q;
   assign blank_o = (rise_c && (len_q != ZERO)) || (cnt_q != ZERO);

   // Length is captured only while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q <= len_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_q  <= 1'b0;
         cnt_q <= ZERO;
      end else begin
         sw_q <= sw_high_i;
         if (rise_c) begin
            cnt_q <= (len_q == ZERO) ? ZERO : len_q - 1'b1;
         end else if (cnt_q != ZERO) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assert_cnt_bound_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != ZERO) |-> (cnt_q < len_q));
   assert_blank_start_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(blank_o) |-> $rose(sw_high_i));
endmodule

// File: rtl/ffm_oc_track.sv
module ffm_oc_track #(
   parameter int unsigned MW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pwm_i,
   input  logic          hs_oc_i,
   input  logic          blank_i,
   input  logic [MW-1:0] mon_code_i,
   input  logic [MW-1:0] lim_code_i,
   output logic          trip_d_o,
   output logic          block_d_o,
   output logic          lock_d_o,
   output logic          flag_d_o
);
   logic [MW-1:0] mon_hold_q;
   logic pwm_q, trip_q, block_q, lock_q, flag_q, clean_q;
   logic pwm_rise, pwm_fall, oc_raw, oc_evt, hs_evt, any_evt;
   logic trip_d, block_d, lock_d, flag_d, clean_d;

   assign pwm_rise = pwm_i && !pwm_q;
   assign pwm_fall = !pwm_i && pwm_q;
   assign oc_raw   = (mon_hold_q > lim_code_i);
   assign oc_evt   = oc_raw && !blank_i;
   assign hs_evt   = hs_oc_i && pwm_i && !blank_i;
   assign any_evt  = hs_evt || oc_evt;

   always_comb begin
      trip_d  = pwm_i && (hs_evt || (trip_q && !pwm_rise));
      block_d = oc_evt || (block_q && (blank_i || oc_raw));
      lock_d  = block_d && (lock_q || hs_evt || trip_q);
      flag_d  = any_evt || (flag_q && !(pwm_fall && clean_q));
      if (pwm_rise) begin
         clean_d = !any_evt;
      end else if (pwm_i && any_evt) begin
         clean_d = 1'b0;
      end else begin
         clean_d = clean_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mon_hold_q <= '0;
         pwm_q      <= 1'b0;
         trip_q     <= 1'b0;
         block_q    <= 1'b0;
         lock_q     <= 1'b0;
         flag_q     <= 1'b0;
         clean_q    <= 1'b1;
      end else begin
         if (!blank_i) begin
            mon_hold_q <= mon_code_i;
         end
         pwm_q   <= pwm_i;
         trip_q  <= trip_d;
         block_q <= block_d;
         lock_q  <= lock_d;
         flag_q  <= flag_d;
         clean_q <= clean_d;
      end
   end

   assign trip_d_o  = trip_d;
   assign block_d_o = block_d;
   assign lock_d_o  = lock_d;
   assign flag_d_o  = flag_d;

   assert_trip_cause_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trip_q) |-> $past(hs_oc_i && pwm_i && !blank_i));
   assert_trip_release_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_i |=> !trip_q);
   assert_lock_needs_block_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |-> block_q);
   assert_flag_clear_edge_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> $past(pwm_q && !pwm_i));
   assert_mon_frozen_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      blank_i |=> $stable(mon_hold_q));
endmodule

// File: rtl/ffm_fault_mgr.sv
module ffm_fault_mgr
   import ffm_pkg::*;
#(
   parameter int unsigned BLANK_W  = 6,
   parameter int unsigned MON_W    = 10,
   parameter int unsigned SUP_W    = 8,
   parameter int unsigned UV_RISE  = 88,
   parameter int unsigned UV_FALL  = 86,
   parameter int unsigned OT_ENTER = 165,
   parameter int unsigned OT_EXIT  = 145
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [BLANK_W-1:0] blank_len_i,
   input  logic               pwm_i,
   input  logic               sw_high_i,
   input  logic               hs_oc_i,
   input  logic [MON_W-1:0]   mon_code_i,
   input  logic [MON_W-1:0]   lim_code_i,
   input  logic [SUP_W-1:0]   vgg_code_i,
   input  logic [SUP_W-1:0]   temp_code_i,
   output logic               fault_flag_o,
   output logic               trunc_hs_o,
   output logic               hold_off_o
);
   generate
      if (BLANK_W < 1 || MON_W < 1 || SUP_W < 1) begin : g_width_bad
         $error("ffm_fault_mgr: widths must be at least one bit");
      end
   endgenerate

   logic blank, uv_q, ot_q;
   logic trip_d, block_d, lock_d, ocflag_d, hold_d;
   logic flag_q, trunc_q, hold_q;

   ffm_blank #(.W(BLANK_W)) blank_i (
      .clk(clk), .rst_n(rst_n), .len_i(blank_len_i),
      .sw_high_i(sw_high_i), .blank_o(blank)
   );

   ffm_oc_track #(.MW(MON_W)) oc_i (
      .clk(clk), .rst_n(rst_n), .pwm_i(pwm_i), .hs_oc_i(hs_oc_i),
      .blank_i(blank), .mon_code_i(mon_code_i), .lim_code_i(lim_code_i),
      .trip_d_o(trip_d), .block_d_o(block_d), .lock_d_o(lock_d),
      .flag_d_o(ocflag_d)
   );

   ffm_hyst #(.W(SUP_W), .SENSE(SENSE_BELOW), .ASSERT_LVL(UV_FALL),
              .RELEASE_LVL(UV_RISE), .RST_ACTIVE(1'b1)) uv_i (
      .clk(clk), .rst_n(rst_n), .code_i(vgg_code_i), .active_o(uv_q)
   );

   ffm_hyst #(.W(SUP_W), .SENSE(SENSE_ABOVE), .ASSERT_LVL(OT_ENTER),
              .RELEASE_LVL(OT_EXIT), .RST_ACTIVE(1'b0)) ot_i (
      .clk(clk), .rst_n(rst_n), .code_i(temp_code_i), .active_o(ot_q)
   );

   assign hold_d = trip_d || lock_d || uv_q || ot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= 1'b1;
         trunc_q <= 1'b1;
         hold_q  <= 1'b1;
      end else begin
         flag_q  <= ocflag_d || uv_q || ot_q;
         hold_q  <= hold_d;
         trunc_q <= hold_d || block_d;
      end
   end

   assign fault_flag_o = flag_q;
   assign trunc_hs_o   = trunc_q;
   assign hold_off_o   = hold_q;

   assert_uv_holds_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      uv_q |=> (hold_off_o && fault_flag_o));
   assert_ot_holds_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      ot_q |=> (hold_off_o && fault_flag_o));
   assert_hold_implies_trunc_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      hold_off_o |-> trunc_hs_o);
   assert_hold_flagged_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      hold_off_o |-> fault_flag_o);
endmodule

// File: tb/ffm_fault_mgr_tb_top.sv
module ffm_fault_mgr_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] blank_len = 6'd4;
   logic       pwm = 1'b0, sw = 1'b0, hs = 1'b0;
   logic [9:0] mon = 10'd10, lim = 10'd100;
   logic [7:0] vgg = 8'd0, temp = 8'd25;
   logic       flag, trunc, hold;
   int         n_tests = 0, n_fail = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   ffm_fault_mgr dut_i (
      .clk(clk), .rst_n(rst_n), .blank_len_i(blank_len), .pwm_i(pwm),
      .sw_high_i(sw), .hs_oc_i(hs), .mon_code_i(mon), .lim_code_i(lim),
      .vgg_code_i(vgg), .temp_code_i(temp), .fault_flag_o(flag),
      .trunc_hs_o(trunc), .hold_off_o(hold)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
      end
   endtask

   // Fault-free pulse; the flag must drop one cycle after PWM falls (R6)
   task automatic clean_pulse(input logic was_set);
      pwm = 1'b1; sw = 1'b1; hs = 1'b0;
      step(8);
      chk("R6", "flag before clean fall", flag, was_set);
      pwm = 1'b0; sw = 1'b0;
      step(1);
      chk("R6", "flag after clean fall", flag, 1'b0);
      step(1);
   endtask

   initial begin
      bit e_st;
      bit seen;
      step(5);
      rst_n = 1'b1;
      blank_len = 6'd9; // must be ignored: length was captured in reset (R2)
      step(0);
      chk("R1", "flag at power-up", flag, 1'b1);
      chk("R1", "trunc at power-up", trunc, 1'b1);
      chk("R1", "hold at power-up", hold, 1'b1);
      vgg = 8'd87; step(4);
      chk("R1", "flag below rise level", flag, 1'b1);

      // R7 sweep, upward then downward, model from the thresholds
      e_st = 1'b1;
      for (int c = 80; c <= 95; c++) begin
         vgg = 8'(c); step(3);
         if (!e_st && c < 86) e_st = 1'b1; else if (e_st && c >= 88) e_st = 1'b0;
         chk("R7", "uv up sweep flag", flag, e_st);
      end
      for (int c = 95; c >= 80; c--) begin
         vgg = 8'(c); step(3);
         if (!e_st && c < 86) e_st = 1'b1; else if (e_st && c >= 88) e_st = 1'b0;
         chk("R7", "uv down sweep hold", hold, e_st);
      end
      vgg = 8'd90; step(3);
      chk("R9", "uv auto clear flag", flag, 1'b0);
      chk("R9", "uv auto clear trunc", trunc, 1'b0);

      // R2 / R3: hit from the switch rising edge, blanking length 4
      pwm = 1'b1; sw = 1'b1; hs = 1'b1;
      for (int i = 1; i <= 4; i++) begin
         step(1);
         chk("R2", "trunc inside blanking", trunc, 1'b0);
      end
      step(1);
      chk("R3", "trunc after blanking", trunc, 1'b1);
      chk("R3", "hold after blanking", hold, 1'b1);
      chk("R3", "flag after hs hit", flag, 1'b1);
      hs = 1'b0; step(2);
      chk("R3", "trip held in pulse", trunc, 1'b1);
      pwm = 1'b0; sw = 1'b0; step(1);
      chk("R3", "trip released at pwm low", hold, 1'b0);
      chk("R6", "flag kept after dirty pulse", flag, 1'b1);
      step(1);
      pwm = 1'b1; sw = 1'b1; hs = 1'b1; step(5);
      chk("R3", "retry truncated again", trunc, 1'b1);
      pwm = 1'b0; sw = 1'b0; hs = 1'b0; step(2);
      clean_pulse(1'b1);

      // R2 sweep of pulse length against the blanking window
      for (int p = 1; p <= 7; p++) begin
         seen = 1'b0;
         pwm = 1'b1; sw = 1'b1; hs = 1'b1;
         for (int i = 0; i < p; i++) begin
            step(1);
            seen = seen | trunc;
         end
         chk("R2", $sformatf("trip for pulse of %0d", p), seen, p > 4);
         pwm = 1'b0; sw = 1'b0; hs = 1'b0; step(2);
         if (p > 4) clean_pulse(1'b1);
      end

      // R4 output overcurrent
      mon = 10'd150; step(3);
      chk("R4", "trunc on oc", trunc, 1'b1);
      chk("R4", "flag on oc", flag, 1'b1);
      chk("R4", "hold stays low on oc", hold, 1'b0);
      pwm = 1'b1; sw = 1'b1; step(8);
      chk("R4", "no hs pulse during oc", trunc, 1'b1);
      pwm = 1'b0; sw = 1'b0; mon = 10'd50; step(3);
      chk("R4", "trunc released", trunc, 1'b0);
      chk("R6", "flag kept after oc pulse", flag, 1'b1);
      clean_pulse(1'b1);
      mon = 10'd100; step(3);
      chk("R4", "equal code no trunc", trunc, 1'b0);
      chk("R4", "equal code no flag", flag, 1'b0);
      mon = 10'd50; step(2);

      // R10 glitch only inside blanking
      pwm = 1'b1; sw = 1'b1; step(1);
      mon = 10'd200; step(2);
      mon = 10'd50;
      for (int i = 0; i < 6; i++) begin
         step(1);
         chk("R10", "blanked glitch ignored", trunc, 1'b0);
      end
      pwm = 1'b0; sw = 1'b0; step(2);
      chk("R10", "no flag from glitch", flag, 1'b0);
      // R10 control: code stays high past blanking, one hold-cycle late
      pwm = 1'b1; sw = 1'b1; step(1);
      mon = 10'd200; step(4);
      chk("R10", "trunc before sample lands", trunc, 1'b0);
      step(1);
      chk("R10", "trunc after sample lands", trunc, 1'b1);
      pwm = 1'b0; sw = 1'b0; mon = 10'd50; step(3);
      clean_pulse(1'b1);

      // R5 combined faults
      pwm = 1'b1; sw = 1'b1; hs = 1'b1; mon = 10'd150; step(8);
      chk("R5", "both off in pulse", hold, 1'b1);
      pwm = 1'b0; sw = 1'b0; hs = 1'b0; step(2);
      chk("R5", "both off after pulse", hold, 1'b1);
      pwm = 1'b1; sw = 1'b1; step(8);
      chk("R5", "both off next pulse", hold, 1'b1);
      chk("R5", "trunc next pulse", trunc, 1'b1);
      pwm = 1'b0; sw = 1'b0; mon = 10'd50; step(3);
      chk("R5", "lock ends with oc", hold, 1'b0);
      chk("R5", "trunc ends with oc", trunc, 1'b0);
      clean_pulse(1'b1);

      // R8 sweep of temperature, up then down
      e_st = 1'b0;
      for (int c = 140; c <= 170; c++) begin
         temp = 8'(c); step(3);
         if (!e_st && c >= 165) e_st = 1'b1; else if (e_st && c < 145) e_st = 1'b0;
         chk("R8", "ot up sweep hold", hold, e_st);
      end
      for (int c = 170; c >= 140; c--) begin
         temp = 8'(c); step(3);
         if (!e_st && c >= 165) e_st = 1'b1; else if (e_st && c < 145) e_st = 1'b0;
         chk("R8", "ot down sweep flag", flag, e_st);
      end
      temp = 8'd166; step(3);
      chk("R9", "ot trunc", trunc, 1'b1);
      temp = 8'd30; step(3);
      chk("R9", "ot auto clear", flag, 1'b0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule